// File: doc/BRIEF.md
# Span Attribute Start Corrector

This block turns a stream of edge-stepped shading attributes into the values that each span begins with. A triangle carries nine shaded channels: red, green, blue, alpha, two texture coordinates, a perspective weight, a level-of-detail term and depth. These reach the block one channel per cycle. Each value is signed fixed point with 16 integer bits (sign included) and 16 fractional bits, held in a 32-bit word. The block corrects each value before the span starts. When the sign of the major edge's inverse slope matches the triangle's major side, it adds three quarters of the edge step and subtracts three quarters of the vertical step. In every case it also removes the horizontal delta scaled by the span's sub-pixel X fraction.

An edge walker drives it with the attribute value, the three deltas and the per-span geometry flags. It raises a new-span pulse on the first channel of each span. The block returns the corrected value and the channel index with a fixed latency of two cycles. It also returns a span-start flag that is the new-span pulse delayed by two cycles. The downstream pixel interpolator uses that flag to load its accumulators.

Top module: `edge_attr_adjust`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `out_valid`, `span_start`, `out_chan` and `out_attr` are all zero.
- R2: When `slope_neg` equals `left_major`, the result is `in_attr + Q(de_attr) - Q(dy_attr) - F`. Here Q(v) = (v>>>1)+(v>>>2) and F is the horizontal term of R5.
- R3: When `slope_neg` differs from `left_major`, the result is `in_attr - F`. The edge and vertical deltas have no effect on it.
- R4: Q uses arithmetic (sign-filling) shifts on the 32-bit two's-complement word, so negative deltas round toward minus infinity. For example, Q(-5) = -3 + -2 = -5.
- R5: F is the exact signed product of `dx_attr` and the unsigned 3-bit `x_frac` (0..7), arithmetically shifted right by 3. When `x_frac` = 0, F is zero.
- R6: A value presented with `in_valid` high appears on `out_attr` with `out_valid` high exactly two clock cycles later. `out_valid` is `in_valid` delayed by two cycles.
- R7: `span_start` equals `new_span` delayed by exactly two cycles, whether or not `in_valid` is high.
- R8: `out_chan` reports a channel index in the order R=0, G=1, B=2, A=3, S=4, T=5, W=6, L=7, Z=8. It advances by one for each valid input, wraps from 8 to 0, and holds across cycles with `in_valid` low.
- R9: A valid input with `new_span` high is tagged channel 0. The following valid inputs count on from 1.
- R10: All additions and subtractions wrap modulo 2^32. Overflow past the largest positive value yields the two's-complement wrapped result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input channel value is present |
| new_span | input | 1 | Marks the first channel of a new span |
| slope_neg | input | 1 | Major-edge inverse slope is negative |
| left_major | input | 1 | Triangle's major edge is on the left |
| x_frac | input | 3 | Unsigned sub-pixel X fraction, in eighths |
| in_attr | input | 32 | Edge-stepped attribute value, signed 15.16 |
| de_attr | input | 32 | Attribute step along the edge, signed 15.16 |
| dx_attr | input | 32 | Attribute step per pixel in X, signed 15.16 |
| dy_attr | input | 32 | Attribute step per line in Y, signed 15.16 |
| out_valid | output | 1 | Corrected value is present |
| out_chan | output | 4 | Channel index of the output value |
| out_attr | output | 32 | Corrected span-start attribute |
| span_start | output | 1 | New-span marker delayed by two cycles |

## Verification
Every result is due exactly two rising edges after the falling edge on which its inputs are driven. This holds for the corrected value, the channel index, the valid flag and the span-start flag. The bench drives on falling edges and keeps a two-entry queue of expected results. At each falling edge it compares the outputs against the entry pushed two steps earlier, before it drives the next input. This keeps every comparison tied to that fixed latency, including runs with idle cycles and span pulses that carry no valid data.

// File: rtl/eas_pkg.sv
package eas_pkg;

   // Channel order within a span; out_chan reports these codes.
   typedef enum logic [3:0] {
      CH_RED   = 4'd0,
      CH_GREEN = 4'd1,
      CH_BLUE  = 4'd2,
      CH_ALPHA = 4'd3,
      CH_S     = 4'd4,
      CH_T     = 4'd5,
      CH_W     = 4'd6,
      CH_LOD   = 4'd7,
      CH_DEPTH = 4'd8
   } chan_e;

   localparam int DEF_NUM_CHAN = 9;
   localparam int PIPE_DEPTH   = 2;

endpackage

// File: rtl/eas_three_quarter.sv
module eas_three_quarter #(
   parameter int W = 32
) (
   input  logic signed [W-1:0] val_i,
   output logic signed [W-1:0] q_o
);

   if (W < 4) begin : g_bad_w
      $error("eas_three_quarter: W must be at least 4");
   end

   logic signed [W-1:0] half_s;
   logic signed [W-1:0] quarter_s;

   always_comb begin
      half_s    = val_i >>> 1;
      quarter_s = val_i >>> 2;
      q_o       = half_s + quarter_s;
   end

endmodule

// File: rtl/eas_frac_scale.sv
module eas_frac_scale #(
   parameter int W      = 32,
   parameter int FW     = 3,
   parameter bit SHIFT_ADD = 1'b0
) (
   input  logic signed [W-1:0]  delta_i,
   input  logic        [FW-1:0] frac_i,
   output logic signed [W-1:0]  term_o
);

   localparam int PW = W + FW;

   if (FW < 1 || FW > 8) begin : g_bad_fw
      $error("eas_frac_scale: FW must lie in 1..8");
   end

   logic signed [PW-1:0] prod_s;
   logic signed [PW-1:0] shifted_s;

   if (SHIFT_ADD) begin : g_shift_add
      logic signed [PW-1:0] ext_s;
      always_comb begin
         ext_s  = PW'(delta_i);
         prod_s = '0;
         for (int i = 0; i < FW; i++) begin
            if (frac_i[i]) prod_s = prod_s + (ext_s <<< i);
         end
      end
   end else begin : g_mult
      logic signed [FW:0] frac_s;
      always_comb begin
         frac_s = $signed({1'b0, frac_i});
         prod_s = PW'(delta_i * frac_s);
      end
   end

   always_comb begin
      shifted_s = prod_s >>> FW;
      term_o    = shifted_s[W-1:0];
   end

endmodule

// File: rtl/eas_chan_seq.sv
module eas_chan_seq #(
   parameter int NUM_CHAN = 9,
   localparam int CW = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv_i,
   input  logic          restart_i,
   output logic [CW-1:0] idx_o
);

   localparam logic [CW-1:0] LAST = CW'(NUM_CHAN - 1);

   logic [CW-1:0] cnt_q;

   always_comb begin
      idx_o = restart_i ? '0 : cnt_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (adv_i) begin
         cnt_q <= (idx_o == LAST) ? '0 : idx_o + CW'(1);
      end
   end

endmodule

// File: rtl/eas_delay.sv
module eas_delay #(
   parameter int W     = 1,
   parameter int DEPTH = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   if (DEPTH < 1) begin : g_bad_depth
      $error("eas_delay: DEPTH must be at least 1");
   end

   logic [W-1:0] stage_q [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            stage_q[g] <= '0;
         end else begin
            stage_q[g] <= (g == 0) ? d_i : stage_q[(g == 0) ? 0 : g-1];
         end
      end
   end

   assign q_o = stage_q[DEPTH-1];

endmodule

// File: rtl/edge_attr_adjust.sv
module edge_attr_adjust
   import eas_pkg::*;
#(
   parameter int ATTR_W    = 32,
   parameter int FRAC_W    = 3,
   parameter int NUM_CHAN  = DEF_NUM_CHAN,
   parameter bit SHIFT_ADD = 1'b0,
   localparam int CHAN_W   = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              new_span,
   input  logic              slope_neg,
   input  logic              left_major,
   input  logic [FRAC_W-1:0] x_frac,
   input  logic [ATTR_W-1:0] in_attr,
   input  logic [ATTR_W-1:0] de_attr,
   input  logic [ATTR_W-1:0] dx_attr,
   input  logic [ATTR_W-1:0] dy_attr,
   output logic              out_valid,
   output logic [CHAN_W-1:0] out_chan,
   output logic [ATTR_W-1:0] out_attr,
   output logic              span_start
);

   if (ATTR_W < 8) begin : g_bad_attr
      $error("edge_attr_adjust: ATTR_W must be at least 8");
   end
   if (NUM_CHAN < 1) begin : g_bad_chan
      $error("edge_attr_adjust: NUM_CHAN must be at least 1");
   end

   // ---------------- stage 0: combinational terms ----------------
   logic signed [ATTR_W-1:0] de_q3_s;
   logic signed [ATTR_W-1:0] dy_q3_s;
   logic signed [ATTR_W-1:0] frac_term_s;
   logic signed [ATTR_W-1:0] corr_s;
   logic                     apply_s;
   logic [CHAN_W-1:0]        chan_s;

   eas_three_quarter #(.W(ATTR_W)) u_q_edge (
      .val_i (de_attr),
      .q_o   (de_q3_s)
   );

   eas_three_quarter #(.W(ATTR_W)) u_q_line (
      .val_i (dy_attr),
      .q_o   (dy_q3_s)
   );

   eas_frac_scale #(.W(ATTR_W), .FW(FRAC_W), .SHIFT_ADD(SHIFT_ADD)) u_frac (
      .delta_i (dx_attr),
      .frac_i  (x_frac),
      .term_o  (frac_term_s)
   );

   eas_chan_seq #(.NUM_CHAN(NUM_CHAN)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .adv_i     (in_valid),
      .restart_i (new_span),
      .idx_o     (chan_s)
   );

   always_comb begin
      apply_s = ~(slope_neg ^ left_major);
      corr_s  = apply_s ? (de_q3_s - dy_q3_s) : '0;
   end

   // ---------------- stage 1 registers ----------------
   logic                     s1_valid_q;
   logic [CHAN_W-1:0]        s1_chan_q;
   logic signed [ATTR_W-1:0] s1_base_q;
   logic signed [ATTR_W-1:0] s1_corr_q;
   logic signed [ATTR_W-1:0] s1_frac_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_valid_q <= 1'b0;
         s1_chan_q  <= '0;
         s1_base_q  <= '0;
         s1_corr_q  <= '0;
         s1_frac_q  <= '0;
      end else begin
         s1_valid_q <= in_valid;
         if (in_valid) begin
            s1_chan_q <= chan_s;
            s1_base_q <= in_attr;
            s1_corr_q <= corr_s;
            s1_frac_q <= frac_term_s;
         end
      end
   end

   // ---------------- stage 2 registers ----------------
   logic signed [ATTR_W-1:0] sum_s;

   always_comb begin
      sum_s = s1_base_q + s1_corr_q - s1_frac_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_chan  <= '0;
         out_attr  <= '0;
      end else begin
         out_valid <= s1_valid_q;
         if (s1_valid_q) begin
            out_chan <= s1_chan_q;
            out_attr <= sum_s;
         end
      end
   end

   // Span marker rides a delay line matched to the data pipeline.
   eas_delay #(.W(1), .DEPTH(PIPE_DEPTH)) u_span_dly (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (new_span),
      .q_o   (span_start)
   );

endmodule

// File: rtl/eas_chk.sv
module eas_chk #(
   parameter int ATTR_W   = 32,
   parameter int FRAC_W   = 3,
   parameter int NUM_CHAN = 9,
   parameter int CHAN_W   = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              new_span,
   input logic              slope_neg,
   input logic              left_major,
   input logic [FRAC_W-1:0] x_frac,
   input logic [ATTR_W-1:0] in_attr,
   input logic              out_valid,
   input logic [CHAN_W-1:0] out_chan,
   input logic [ATTR_W-1:0] out_attr,
   input logic              span_start
);

   logic [1:0]        cyc_q;
   logic              seen_q;
   logic [CHAN_W-1:0] last_q;
   logic [CHAN_W-1:0] next_s;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cyc_q  <= '0;
         seen_q <= 1'b0;
         last_q <= '0;
      end else begin
         if (cyc_q != 2'd2) cyc_q <= cyc_q + 2'd1;
         if (out_valid) begin
            seen_q <= 1'b1;
            last_q <= out_chan;
         end
      end
   end

   always_comb begin
      next_s = (last_q == CHAN_W'(NUM_CHAN - 1)) ? '0 : last_q + CHAN_W'(1);
   end

   // R7
   span_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_q == 2'd2) |-> (span_start == $past(new_span, 2)));

   // R6
   valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_q == 2'd2) |-> (out_valid == $past(in_valid, 2)));

   // R8
   chan_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_chan <= CHAN_W'(NUM_CHAN - 1)));

   // R9
   restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((cyc_q == 2'd2) && $past(in_valid && new_span, 2)) |-> (out_chan == '0));

   // R8
   chan_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !span_start && seen_q) |-> (out_chan == next_s));

   // R3
   passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((cyc_q == 2'd2) && $past(in_valid && (slope_neg ^ left_major) && (x_frac == '0), 2))
         |-> (out_attr == $past(in_attr, 2)));

endmodule

bind edge_attr_adjust eas_chk #(
   .ATTR_W   (ATTR_W),
   .FRAC_W   (FRAC_W),
   .NUM_CHAN (NUM_CHAN),
   .CHAN_W   (CHAN_W)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .new_span   (new_span),
   .slope_neg  (slope_neg),
   .left_major (left_major),
   .x_frac     (x_frac),
   .in_attr    (in_attr),
   .out_valid  (out_valid),
   .out_chan   (out_chan),
   .out_attr   (out_attr),
   .span_start (span_start)
);

// File: tb/edge_attr_adjust_tb_top.sv
module edge_attr_adjust_tb_top;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid, new_span, slope_neg, left_major;
   logic [2:0]  x_frac;
   logic [31:0] in_attr, de_attr, dx_attr, dy_attr;
   logic        out_valid;
   logic [3:0]  out_chan;
   logic [31:0] out_attr;
   logic        span_start;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   edge_attr_adjust dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .new_span(new_span),
      .slope_neg(slope_neg), .left_major(left_major), .x_frac(x_frac),
      .in_attr(in_attr), .de_attr(de_attr), .dx_attr(dx_attr), .dy_attr(dy_attr),
      .out_valid(out_valid), .out_chan(out_chan), .out_attr(out_attr),
      .span_start(span_start)
   );

   // expected-result queue, two entries deep
   logic        p_v  [2];
   logic        p_ns [2];
   logic [31:0] p_at [2];
   logic [3:0]  p_ch [2];
   string       p_tag[2];
   int          b_cnt;

   function automatic logic [31:0] q3(input logic [31:0] v);
      logic signed [31:0] s;
      s = $signed(v);
      return 32'((s >>> 1) + (s >>> 2));
   endfunction

   function automatic logic [31:0] fterm(input logic [31:0] dx, input logic [2:0] xf);
      logic signed [35:0] p;
      p = 36'($signed(dx)) * 36'($signed({33'd0, xf}));
      p = p >>> 3;
      return p[31:0];
   endfunction

   function automatic logic [31:0] model(input logic neg, input logic lm, input logic [2:0] xf,
                                         input logic [31:0] a, input logic [31:0] de,
                                         input logic [31:0] dx, input logic [31:0] dy);
      if (neg == lm) return a + q3(de) - q3(dy) - fterm(dx, xf);
      return a - fterm(dx, xf);
   endfunction

   task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // One falling-edge step: compare the entry queued two steps ago, then drive.
   task automatic step(input logic v, input logic ns, input logic neg, input logic lm,
                       input logic [2:0] xf, input logic [31:0] a, input logic [31:0] de,
                       input logic [31:0] dx, input logic [31:0] dy, input string tag);
      int idx;
      chk(out_valid == p_v[1], "R6 valid", 32'(out_valid), 32'(p_v[1]));
      chk(span_start == p_ns[1], "R7 span_start", 32'(span_start), 32'(p_ns[1]));
      if (p_v[1]) begin
         chk(out_attr == p_at[1], p_tag[1], out_attr, p_at[1]);
         chk(out_chan == p_ch[1], "R8/R9 chan", 32'(out_chan), 32'(p_ch[1]));
      end
      p_v[1] = p_v[0]; p_ns[1] = p_ns[0]; p_at[1] = p_at[0];
      p_ch[1] = p_ch[0]; p_tag[1] = p_tag[0];
      idx = ns ? 0 : b_cnt;
      if (v) b_cnt = (idx == 8) ? 0 : idx + 1;
      p_v[0] = v; p_ns[0] = ns; p_ch[0] = 4'(idx);
      p_at[0] = model(neg, lm, xf, a, de, dx, dy);
      p_tag[0] = tag;
      in_valid = v; new_span = ns; slope_neg = neg; left_major = lm;
      x_frac = xf; in_attr = a; de_attr = de; dx_attr = dx; dy_attr = dy;
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(0, 0, 0, 0, 3'd0, 0, 0, 0, 0, "idle");
   endtask

   task automatic t_reset();
      chk(out_valid == 0, "R1 out_valid", 32'(out_valid), 0);
      chk(span_start == 0, "R1 span_start", 32'(span_start), 0);
      chk(out_attr == 0, "R1 out_attr", out_attr, 0);
      chk(out_chan == 0, "R1 out_chan", 32'(out_chan), 0);
   endtask

   task automatic t_applied();
      // R2: slope sign matches major side, both polarities
      step(1, 1, 1, 1, 3'd4, 32'h0001_0000, 32'h0004_0000, 32'h0000_8000, 32'h0000_8000, "R2 neg/left");
      step(1, 0, 0, 0, 3'd0, 32'h0010_0000, 32'h0002_0000, 32'h0003_0000, 32'h0001_0000, "R2 pos/right");
      step(1, 0, 1, 1, 3'd7, 32'h1234_5678, 32'h0ABC_DEF0, 32'h0101_0101, 32'h0F00_0000, "R2 mixed");
      idle(2);
   endtask

   task automatic t_bypass();
      // R3: deltas on the edge and line have no effect
      step(1, 1, 0, 1, 3'd0, 32'h0005_0000, 32'h7FFF_0000, 32'h0000_0000, 32'h1234_0000, "R3 pos/left");
      step(1, 0, 1, 0, 3'd0, 32'hFFFF_0000, 32'h8000_0000, 32'h0100_0000, 32'h4000_0000, "R3 neg/right");
      step(1, 0, 1, 0, 3'd5, 32'h0040_0000, 32'h1111_1111, 32'h0008_0000, 32'h2222_2222, "R3 with frac");
      idle(2);
   endtask

   task automatic t_neg_shift();
      // R4: arithmetic shifts on negative deltas
      step(1, 1, 1, 1, 3'd0, 32'h0000_0000, 32'hFFFF_FFFB, 32'h0, 32'h0, "R4 Q(-5)");
      step(1, 0, 0, 0, 3'd0, 32'h0000_0100, 32'h0, 32'h0, 32'hFFFF_FFFD, "R4 Q(-3) on dy");
      step(1, 0, 0, 0, 3'd0, 32'h0000_0000, 32'h8000_0000, 32'h0, 32'h0, "R4 most negative");
      idle(2);
   endtask

   task automatic t_frac();
      // R5: sweep the sub-pixel fraction with positive and negative dx
      for (int f = 0; f < 8; f++)
         step(1, (f == 0), 0, 1, 3'(f), 32'h0100_0000, 32'h0, 32'h0001_0007, 32'h0, "R5 frac +dx");
      for (int f = 0; f < 8; f++)
         step(1, 0, 1, 0, 3'(f), 32'h0000_0000, 32'h0, 32'hFFFE_FFF9, 32'h0, "R5 frac -dx");
      idle(2);
   endtask

   task automatic t_wrap();
      // R10: modulo 2^32 arithmetic
      step(1, 1, 0, 0, 3'd0, 32'h7FFF_FFFF, 32'h0000_0008, 32'h0, 32'h0, "R10 add overflow");
      step(1, 0, 1, 0, 3'd7, 32'h8000_0000, 32'h0, 32'h0000_0100, 32'h0, "R10 sub underflow");
      idle(2);
   endtask

   task automatic t_chan();
      // R8: wrap past channel 8, hold across idle cycles
      step(1, 1, 0, 1, 3'd0, 32'd1, 0, 0, 0, "R8 seq");
      for (int i = 0; i < 11; i++) step(1, 0, 0, 1, 3'd0, 32'(i + 2), 0, 0, 0, "R8 seq");
      idle(3);
      for (int i = 0; i < 4; i++) step(1, 0, 0, 1, 3'd0, 32'(i + 20), 0, 0, 0, "R8 after gap");
      idle(2);
   endtask

   task automatic t_restart();
      // R9: restart mid-sequence; R7: span pulse with no valid data
      for (int i = 0; i < 5; i++) step(1, (i == 0), 1, 1, 3'd2, 32'(i * 3), 32'd4, 32'd8, 32'd4, "R9 pre");
      step(1, 1, 1, 1, 3'd2, 32'd100, 32'd4, 32'd8, 32'd4, "R9 restart");
      step(1, 0, 1, 1, 3'd2, 32'd101, 32'd4, 32'd8, 32'd4, "R9 after");
      step(0, 1, 0, 0, 3'd0, 0, 0, 0, 0, "R7 bare pulse");
      step(1, 0, 1, 1, 3'd0, 32'd7, 0, 0, 0, "R7 after bare pulse");
      idle(3);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < 2; i++) begin
         p_v[i] = 0; p_ns[i] = 0; p_at[i] = 0; p_ch[i] = 0; p_tag[i] = "none";
      end
      b_cnt = 0;
      rst_n = 0; in_valid = 0; new_span = 0; slope_neg = 0; left_major = 0;
      x_frac = 0; in_attr = 0; de_attr = 0; dx_attr = 0; dy_attr = 0;
      repeat (4) @(negedge clk);
      t_reset();
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_applied();
      t_bypass();
      t_neg_shift();
      t_frac();
      t_wrap();
      t_chan();
      t_restart();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule